// File: doc/BRIEF.md
# Infrared Transmit Pattern Timer

This block shapes the on/off envelope of an infrared transmit line. A host writes a start value into a down counter. The counter steps once every `PRESC` system clocks. While the count is non-zero, the transmit output carries either a modulated carrier or a steady high level. A control bit picks between the two. The carrier comes from the system clock through a divider with separate high and low phase lengths.

When the count reaches zero, the block raises a sticky done flag, which the host clears with its next count write. A carrier burst is never cut short: after the timer stops, the current carrier period runs to the end of its low phase before the output goes quiet. An indicator output, enabled by a second control bit, repeats the transmit output in step so that a visible lamp can follow the transmission.

Top module: `ir_pattern_timer`

## Requirements
- R1: The count register is `CNT_W` bits wide (default 9). It decrements by one every `PRESC` clocks while non-zero, so a count of N written at clock edge e0 becomes zero at edge e0 + N*PRESC.
- R2: Writing zero leaves the timer stopped. The transmit output stays low and the done flag is not set.
- R3: With control bit 2 clear, the transmit output is a carrier. It is high for `CAR_HI` clocks and low for `CAR_LO` clocks, and the first high phase starts in the cycle right after the count write.
- R4: With control bit 2 set, the transmit output is a steady high level for exactly the N*PRESC cycles that the count is non-zero.
- R5: When the count reaches zero, the carrier finishes its current period before stopping. Every carrier pulse is exactly `CAR_HI` cycles long, a run of T = N*PRESC cycles produces ceil(T/(CAR_HI+CAR_LO)) pulses, and the output then stays low.
- R6: The done flag rises in the same cycle that the count reaches zero. It stays set until a count write of any value clears it.
- R7: With control bit 3 set, the indicator output equals the transmit output in every cycle. With bit 3 clear, the indicator output stays low.
- R8: After reset, the control register reads 8'h03, and the transmit output, the indicator output and the done flag are all low. A control write is readable on the next cycle.
- R9: A count write while the timer is running restarts the countdown from the new value, with a fresh prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Value loaded into the down counter |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value; bit 2 = steady mode, bit 3 = indicator enable |
| ctl_q | output | 8 | Control register contents |
| done | output | 1 | Sticky flag, set when the count reaches zero |
| tx_out | output | 1 | Active-high infrared transmit output |
| ind_out | output | 1 | Indicator output that follows the transmit output |

## Verification
The bench builds the block with `PRESC`=3, `CAR_HI`=2 and `CAR_LO`=3. With these values a five-cycle carrier period is much shorter than a countdown, so a single run crosses many period boundaries. The runs cover expiry both at and between period boundaries, and a full 511-count run that exercises the widest 9-bit value. The short prescaler also makes the exact done cycle, a restart in mid-count and the drain of the last carrier period visible within a few dozen cycles of each write.

// File: rtl/ir_pattern_timer.sv
module ir_pattern_timer #(
  parameter int           CNT_W   = 9,
  parameter int           PRESC   = 64,
  parameter int           CAR_HI  = 35,
  parameter int           CAR_LO  = 70,
  parameter logic [7:0]   CTL_RST = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_q,
  output logic             done,
  output logic             tx_out,
  output logic             ind_out
);

  localparam int PW   = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam int CMAX = (CAR_HI > CAR_LO) ? CAR_HI : CAR_LO;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]    pre_q;
  logic [CW-1:0]    cc_q;
  logic             ph_hi, busy, done_q;

  wire run    = cnt_q != '0;
  wire run_d  = cnt_d != '0;
  wire tick   = pre_q == PW'(PRESC - 1);
  wire end_hi = ph_hi  && (cc_q == CW'(CAR_HI - 1));
  wire end_lo = !ph_hi && (cc_q == CW'(CAR_LO - 1));
  wire gen_on = run | busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_wr) ctl_q <= ctl_wdata;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr)           cnt_d = cnt_wdata;
    else if (run && tick) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (cnt_wr || !run || tick) pre_q <= '0;
      else                        pre_q <= pre_q + 1'b1;
      if (cnt_wr)                                      done_q <= 1'b0;
      else if (run && tick && cnt_q == CNT_W'(1))      done_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_hi <= 1'b1;
      cc_q  <= '0;
      busy  <= 1'b0;
    end else if (!gen_on) begin
      ph_hi <= 1'b1;
      cc_q  <= '0;
      busy  <= 1'b0;
    end else begin
      busy <= !(end_lo && !run_d);
      if (end_hi) begin
        ph_hi <= 1'b0;
        cc_q  <= '0;
      end else if (end_lo) begin
        ph_hi <= 1'b1;
        cc_q  <= '0;
      end else begin
        cc_q  <= cc_q + 1'b1;
      end
    end

  assign done    = done_q;
  assign tx_out  = ctl_q[2] ? run : (gen_on & ph_hi);
  assign ind_out = ctl_q[3] & tx_out;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1))); // R1

  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (run || done)); // R6

  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cnt_wdata == '0) |=> (!run && !done)); // R2

  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !busy) |-> !tx_out); // R5

  AST_END_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(!ph_hi)); // R5

endmodule

// File: tb/sim_ir_pattern_timer.sv
module sim_ir_pattern_timer;
  localparam int PRESC = 3;
  localparam int HI    = 2;
  localparam int LO    = 3;
  localparam int P     = HI + LO;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cnt_wr = 1'b0, ctl_wr = 1'b0;
  logic [8:0] cnt_wdata = '0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_q;
  logic       done, tx_out, ind_out;
  int         nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  ir_pattern_timer #(.CNT_W(9), .PRESC(PRESC), .CAR_HI(HI), .CAR_LO(LO)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .done(done),
    .tx_out(tx_out), .ind_out(ind_out));

  // {ind_en, steady, count}
  localparam logic [10:0] VEC [0:5] = '{
    {1'b0, 1'b0, 9'd1},
    {1'b0, 1'b0, 9'd5},
    {1'b1, 1'b0, 9'd4},
    {1'b1, 1'b1, 9'd7},
    {1'b0, 1'b1, 9'd2},
    {1'b1, 1'b0, 9'd511}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input logic [8:0] v);
    cnt_wdata = v; cnt_wr = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic meas(input int lim, input bit ind_en, output int t_done, output int hi,
                      output int rises, output int ind_bad, output int runt);
    logic prev;
    int   plen;
    prev = 1'b0; plen = 0;
    t_done = -1; hi = 0; rises = 0; ind_bad = 0; runt = 0;
    for (int j = 0; j < lim; j++) begin
      if (done && t_done < 0) t_done = j;
      if (tx_out) begin
        hi++; plen++;
        if (!prev) rises++;
      end else begin
        if (prev && plen != HI) runt++;
        plen = 0;
      end
      if (ind_out !== (ind_en & tx_out)) ind_bad++;
      prev = tx_out;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int td, hi, rs, ib, rn;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_q == 8'h03, "R8 ctl reset", ctl_q, 8'h03);
    chk(!tx_out, "R8 tx reset", tx_out, 0);
    chk(!ind_out, "R8 ind reset", ind_out, 0);
    chk(!done, "R8 done reset", done, 0);

    wr_ctl(8'h0B);
    wr_cnt(9'd0);
    meas(15, 1'b1, td, hi, rs, ib, rn);
    chk(hi == 0, "R2 zero write tx", hi, 0);
    chk(td == -1, "R2 zero write done", td, -1);

    for (int i = 0; i < 6; i++) begin
      int n, t, ehi, ers;
      bit ind_en, steady;
      n = int'(VEC[i][8:0]); steady = VEC[i][9]; ind_en = VEC[i][10];
      t = n * PRESC;
      if (steady) begin ehi = t; ers = 1; end
      else begin ers = (t + P - 1) / P; ehi = ers * HI; end
      wr_ctl({4'b0, ind_en, steady, 2'b11});
      wr_cnt(n[8:0]);
      meas(t + P + 4, ind_en, td, hi, rs, ib, rn);
      chk(td == t, "R1 R6 done cycle", td, t);
      chk(hi == ehi, steady ? "R4 steady high cycles" : "R3 carrier high cycles", hi, ehi);
      chk(rs == ers, steady ? "R4 single pulse" : "R5 pulse count", rs, ers);
      chk(ib == 0, "R7 indicator mismatch", ib, 0);
      if (!steady) chk(rn == 0, "R5 runt pulses", rn, 0);
    end

    chk(done, "R6 done held", done, 1);
    wr_cnt(9'd0);
    chk(!done, "R6 done cleared by write", done, 0);

    wr_ctl(8'h04);
    wr_cnt(9'd4);
    repeat (5) @(negedge clk);
    wr_cnt(9'd2);
    meas(12, 1'b0, td, hi, rs, ib, rn);
    chk(td == 2 * PRESC, "R9 restart done cycle", td, 2 * PRESC);
    chk(hi == 2 * PRESC, "R9 restart high cycles", hi, 2 * PRESC);

    wr_ctl(8'hA5);
    chk(ctl_q == 8'hA5, "R8 ctl readback", ctl_q, 8'hA5);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule